// File: doc/BRIEF.md
# Precision Time Counter with Offset Update and Alarm

This block keeps a running precision time made of a seconds word and a nanosecond subseconds word. Software programs it through a flat register file written with a single-cycle write strobe and read combinationally. Once enabled, the time advances on every clock. Two rate modes are available. In coarse mode a fixed increment is added every clock. In fine mode a 32-bit addend is summed into a phase accumulator, and the increment is applied only when that accumulator wraps.

A one-shot update request adds a programmed seconds/subseconds offset pair to the live time, carrying across the subseconds wrap, and then clears itself. An alarm compares the time against a programmed pair. When both words match, it sets a sticky status flag. The flag drives an interrupt output when the interrupt is enabled.

Register addresses (4-bit word address): 0 control, 1 status, 2 current seconds (read only), 3 current subseconds (read only), 4 offset seconds, 5 offset subseconds, 6 alarm seconds, 7 alarm subseconds, 8 subseconds increment, 9 fine-mode addend.

Top module: `ptp_time_counter`

## Requirements
- R1: After synchronous reset the control word, status flag, seconds, subseconds and fine accumulator are all zero, so nothing counts and irq is low.
- R2: Control bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the rate (0 coarse, 1 fine), bit 3 requests an update, and bit 5 enables the alarm; bit 4 and bits 31:6 ignore writes and read as zero.
- R3: With counting enabled and bit 3 set, the next clock adds the offset pair to the time instead of an increment, and bit 3 reads zero afterwards.
- R4: In coarse mode each enabled clock adds the increment register (address 8) to the subseconds.
- R5: The subseconds stay below the rollover limit (10^9 by default); an addition reaching it subtracts the limit and adds one second, during both increments and updates.
- R6: In fine mode each enabled clock adds the addend (address 9) to a 32-bit accumulator, and the subseconds advance by the increment only on a carry out of that accumulator.
- R7: With counting and the alarm enabled, the status flag (status bit 0) sets on the same clock that the time changes to a value equal to the alarm seconds and alarm subseconds.
- R8: With the alarm disabled, reaching the alarm value does not set the status flag.
- R9: With counting disabled the time holds, and a requested update stays pending (bit 3 reads one) until counting is enabled.
- R10: The status flag stays set until software writes 1 to status bit 0; irq is high exactly when the flag and control bit 1 are both set.
- R11: The register map uses word addresses 0 control, 1 status, 2 seconds, 3 subseconds, 4/5 offset seconds/subseconds, 6/7 alarm seconds/subseconds, 8 increment, 9 addend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| time_sec | output | SEC_W | Current seconds |
| time_sub | output | SUB_W | Current subseconds in nanoseconds |
| alarm_flag | output | 1 | Sticky alarm status |
| irq | output | 1 | Alarm interrupt |

## Verification
A register write takes effect on the clock edge that samples the strobe, and its effect can be read at the next falling edge. The time changes one further edge later, because the counter acts on the registered control word. So an enabling write is followed by exactly one step per later edge, and an update appears one edge after the write that sets both enable and bit 3. The alarm flag sets on the same edge that the time reaches the alarm value, and irq follows the flag without delay. The bench drives and samples only on falling edges, counts steps from the enabling write, and computes the expected seconds and subseconds as integer quotient and remainder of the accumulated nanoseconds.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    localparam int CB_EN   = 0;
    localparam int CB_IRQ  = 1;
    localparam int CB_FINE = 2;
    localparam int CB_UPD  = 3;
    localparam int CB_ALM  = 5;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 4'd0,
        RA_STATUS  = 4'd1,
        RA_SEC     = 4'd2,
        RA_SUB     = 4'd3,
        RA_OFS_SEC = 4'd4,
        RA_OFS_SUB = 4'd5,
        RA_ALM_SEC = 4'd6,
        RA_ALM_SUB = 4'd7,
        RA_INC     = 4'd8,
        RA_ADDEND  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic alm_en;
        logic upd;
        logic fine;
        logic irq_en;
        logic en;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [REG_DW-1:0] w);
        ctrl_t c;
        c.en     = w[CB_EN];
        c.irq_en = w[CB_IRQ];
        c.fine   = w[CB_FINE];
        c.upd    = w[CB_UPD];
        c.alm_en = w[CB_ALM];
        return c;
    endfunction

    function automatic logic [REG_DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_DW-1:0] w;
        w          = '0;
        w[CB_EN]   = c.en;
        w[CB_IRQ]  = c.irq_en;
        w[CB_FINE] = c.fine;
        w[CB_UPD]  = c.upd;
        w[CB_ALM]  = c.alm_en;
        return w;
    endfunction

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32,
    parameter int ACC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              upd_done,
    input  logic              alarm_set,
    input  logic [SEC_W-1:0]  time_sec,
    input  logic [SUB_W-1:0]  time_sub,
    output ctrl_t             ctrl,
    output logic [SEC_W-1:0]  ofs_sec,
    output logic [SUB_W-1:0]  ofs_sub,
    output logic [SEC_W-1:0]  alm_sec,
    output logic [SUB_W-1:0]  alm_sub,
    output logic [SUB_W-1:0]  inc,
    output logic [ACC_W-1:0]  addend,
    output logic              alarm_flag,
    output logic [REG_DW-1:0] rdata
);

    reg_addr_e ra;
    logic      wr_ctrl;
    logic      wr_status;

    assign ra        = reg_addr_e'(addr);
    assign wr_ctrl   = wr_en && (ra == RA_CTRL);
    assign wr_status = wr_en && (ra == RA_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= word_to_ctrl(wdata);
        end else if (upd_done) begin
            ctrl.upd <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_flag <= 1'b0;
        end else if (alarm_set) begin
            alarm_flag <= 1'b1;
        end else if (wr_status && wdata[0]) begin
            alarm_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_sec <= '0;
            ofs_sub <= '0;
            alm_sec <= '0;
            alm_sub <= '0;
            inc     <= '0;
            addend  <= '0;
        end else if (wr_en) begin
            case (ra)
                RA_OFS_SEC: ofs_sec <= wdata[SEC_W-1:0];
                RA_OFS_SUB: ofs_sub <= wdata[SUB_W-1:0];
                RA_ALM_SEC: alm_sec <= wdata[SEC_W-1:0];
                RA_ALM_SUB: alm_sub <= wdata[SUB_W-1:0];
                RA_INC:     inc     <= wdata[SUB_W-1:0];
                RA_ADDEND:  addend  <= wdata[ACC_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (ra)
            RA_CTRL:    rdata = ctrl_to_word(ctrl);
            RA_STATUS:  rdata[0] = alarm_flag;
            RA_SEC:     rdata = REG_DW'(time_sec);
            RA_SUB:     rdata = REG_DW'(time_sub);
            RA_OFS_SEC: rdata = REG_DW'(ofs_sec);
            RA_OFS_SUB: rdata = REG_DW'(ofs_sub);
            RA_ALM_SEC: rdata = REG_DW'(alm_sec);
            RA_ALM_SUB: rdata = REG_DW'(alm_sub);
            RA_INC:     rdata = REG_DW'(inc);
            RA_ADDEND:  rdata = REG_DW'(addend);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptp_tc_core.sv
module ptp_tc_core
    import ptp_tc_pkg::*;
#(
    parameter int          SEC_W = 32,
    parameter int          SUB_W = 32,
    parameter int          ACC_W = 32,
    parameter int unsigned ROLL  = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [SUB_W-1:0] inc,
    input  logic [ACC_W-1:0] addend,
    input  logic [SEC_W-1:0] ofs_sec,
    input  logic [SUB_W-1:0] ofs_sub,
    output logic [SEC_W-1:0] time_sec,
    output logic [SUB_W-1:0] time_sub,
    output logic [SEC_W-1:0] nxt_sec,
    output logic [SUB_W-1:0] nxt_sub,
    output logic             step,
    output logic             upd_done
);

    localparam logic [SUB_W:0] ROLL_V = ROLL[SUB_W:0];

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;
    logic             acc_carry;
    logic [SUB_W-1:0] add_sub;
    logic [SEC_W-1:0] add_sec;
    logic [SUB_W:0]   sub_sum;
    logic [SUB_W:0]   sub_adj;
    logic             wrap;

    always_comb begin
        acc_sum   = {1'b0, acc_q} + {1'b0, addend};
        acc_carry = acc_sum[ACC_W];

        add_sub   = ctrl.upd ? ofs_sub : inc;
        add_sec   = ctrl.upd ? ofs_sec : '0;

        step      = ctrl.en && (ctrl.upd || !ctrl.fine || acc_carry);
        upd_done  = ctrl.en && ctrl.upd;

        sub_sum   = {1'b0, time_sub} + {1'b0, add_sub};
        wrap      = (sub_sum >= ROLL_V);
        sub_adj   = wrap ? (sub_sum - ROLL_V) : sub_sum;
        nxt_sub   = sub_adj[SUB_W-1:0];
        nxt_sec   = time_sec + add_sec + {{(SEC_W-1){1'b0}}, wrap};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            time_sec <= '0;
            time_sub <= '0;
        end else begin
            if (ctrl.en && ctrl.fine && !ctrl.upd) begin
                acc_q <= acc_sum[ACC_W-1:0];
            end
            if (step) begin
                time_sec <= nxt_sec;
                time_sub <= nxt_sub;
            end
        end
    end

endmodule

// File: rtl/ptp_tc_alarm.sv
module ptp_tc_alarm #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32
) (
    input  logic             alm_en,
    input  logic             step,
    input  logic [SEC_W-1:0] nxt_sec,
    input  logic [SUB_W-1:0] nxt_sub,
    input  logic [SEC_W-1:0] alm_sec,
    input  logic [SUB_W-1:0] alm_sub,
    output logic             alarm_set
);

    logic sec_hit;
    logic sub_hit;

    assign sec_hit   = (nxt_sec == alm_sec);
    assign sub_hit   = (nxt_sub == alm_sub);
    assign alarm_set = alm_en && step && sec_hit && sub_hit;

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int          SEC_W = 32,
    parameter int          SUB_W = 32,
    parameter int          ACC_W = 32,
    parameter int unsigned ROLL  = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    output logic [SEC_W-1:0]  time_sec,
    output logic [SUB_W-1:0]  time_sub,
    output logic              alarm_flag,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [SEC_W-1:0] ofs_sec;
    logic [SUB_W-1:0] ofs_sub;
    logic [SEC_W-1:0] alm_sec;
    logic [SUB_W-1:0] alm_sub;
    logic [SUB_W-1:0] inc_q;
    logic [ACC_W-1:0] addend_q;
    logic [SEC_W-1:0] nxt_sec;
    logic [SUB_W-1:0] nxt_sub;
    logic             step;
    logic             upd_done;
    logic             alarm_set;

    logic cfg_en;
    logic cfg_fine;
    logic cfg_upd;
    logic cfg_alm_en;

    assign cfg_en     = ctrl_q.en;
    assign cfg_fine   = ctrl_q.fine;
    assign cfg_upd    = ctrl_q.upd;
    assign cfg_alm_en = ctrl_q.alm_en;

    ptp_tc_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .upd_done   (upd_done),
        .alarm_set  (alarm_set),
        .time_sec   (time_sec),
        .time_sub   (time_sub),
        .ctrl       (ctrl_q),
        .ofs_sec    (ofs_sec),
        .ofs_sub    (ofs_sub),
        .alm_sec    (alm_sec),
        .alm_sub    (alm_sub),
        .inc        (inc_q),
        .addend     (addend_q),
        .alarm_flag (alarm_flag),
        .rdata      (rdata)
    );

    ptp_tc_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ACC_W(ACC_W), .ROLL(ROLL)) core_i (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .inc      (inc_q),
        .addend   (addend_q),
        .ofs_sec  (ofs_sec),
        .ofs_sub  (ofs_sub),
        .time_sec (time_sec),
        .time_sub (time_sub),
        .nxt_sec  (nxt_sec),
        .nxt_sub  (nxt_sub),
        .step     (step),
        .upd_done (upd_done)
    );

    ptp_tc_alarm #(.SEC_W(SEC_W), .SUB_W(SUB_W)) alarm_i (
        .alm_en    (ctrl_q.alm_en),
        .step      (step),
        .nxt_sec   (nxt_sec),
        .nxt_sub   (nxt_sub),
        .alm_sec   (alm_sec),
        .alm_sub   (alm_sub),
        .alarm_set (alarm_set)
    );

    assign irq = alarm_flag && ctrl_q.irq_en;

endmodule

// File: rtl/ptp_tc_chk.sv
module ptp_tc_chk
    import ptp_tc_pkg::*;
#(
    parameter int          SEC_W = 32,
    parameter int          SUB_W = 32,
    parameter int unsigned ROLL  = 1_000_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [REG_DW-1:0] wdata,
    input logic [SEC_W-1:0]  time_sec,
    input logic [SUB_W-1:0]  time_sub,
    input logic              alarm_flag,
    input logic              cfg_en,
    input logic              cfg_fine,
    input logic              cfg_upd,
    input logic              cfg_alm_en,
    input logic [SUB_W-1:0]  inc_q
);

    localparam logic [SUB_W:0] ROLL_V = ROLL[SUB_W:0];

    logic clr_req;
    logic ctrl_wr;
    assign clr_req = wr_en && (addr == RA_STATUS) && wdata[0];
    assign ctrl_wr = wr_en && (addr == RA_CTRL);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (time_sec == '0 && time_sub == '0 && !alarm_flag));

    assert_upd_self_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_upd && !ctrl_wr) |=> !cfg_upd);

    assert_coarse_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_fine && !cfg_upd &&
         (({1'b0, time_sub} + {1'b0, inc_q}) < ROLL_V))
        |=> (time_sub == $past(time_sub) + $past(inc_q)) && $stable(time_sec));

    assert_sub_below_roll_R5: assert property (@(posedge clk) disable iff (rst)
        {1'b0, time_sub} < ROLL_V);

    assert_no_alarm_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_alm_en && !alarm_flag) |=> !alarm_flag);

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> ($stable(time_sec) && $stable(time_sub)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_req) |=> alarm_flag);

endmodule

bind ptp_time_counter ptp_tc_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ROLL(ROLL)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .time_sec   (time_sec),
    .time_sub   (time_sub),
    .alarm_flag (alarm_flag),
    .cfg_en     (cfg_en),
    .cfg_fine   (cfg_fine),
    .cfg_upd    (cfg_upd),
    .cfg_alm_en (cfg_alm_en),
    .inc_q      (inc_q)
);

// File: tb/ptp_time_counter_tb_top.sv
module ptp_time_counter_tb_top;

    localparam int          SEC_W = 16;
    localparam int          SUB_W = 32;
    localparam int unsigned ROLL  = 1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [3:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [SEC_W-1:0]  time_sec;
    logic [SUB_W-1:0]  time_sub;
    logic              alarm_flag;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptp_time_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W), .ROLL(ROLL)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .time_sec   (time_sec),
        .time_sub   (time_sub),
        .alarm_flag (alarm_flag),
        .irq        (irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_time(input string req, input longint total_ns);
        check(req, longint'(time_sec), (total_ns / ROLL) % (longint'(1) << SEC_W));
        check(req, longint'(time_sub), total_ns % ROLL);
    endtask

    initial begin
        logic [31:0] d;
        longint cur, tot;
        @(negedge clk);
        do_reset();

        // R1 reset state, R11 read addresses
        rd(4'd0, d); check("R1 ctrl", d, 0);
        rd(4'd1, d); check("R1 status", d, 0);
        rd(4'd2, d); check("R1 sec", d, 0);
        rd(4'd3, d); check("R1 sub", d, 0);
        check("R1 irq", irq, 0);

        // R2 reserved bits read zero, defined bits read back
        wr(4'd0, 32'hFFFF_FFD0);
        rd(4'd0, d); check("R2 reserved", d, 0);
        wr(4'd0, 32'h0000_0026);
        rd(4'd0, d); check("R2 fields", d, 32'h26);
        repeat (3) @(negedge clk);
        check_time("R2 no count while bit0 low", 0);
        wr(4'd0, 32'h0);
        wr(4'd8, 32'd123);
        rd(4'd8, d); check("R11 increment address", d, 123);

        // R4 R5 coarse sweep across several rollovers
        wr(4'd8, 32'd7);
        wr(4'd0, 32'h1);
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            check_time("R4 R5 coarse", longint'(k) * 7);
        end

        // R9 hold while disabled, pending update
        wr(4'd0, 32'h0);
        cur = longint'(time_sec) * ROLL + longint'(time_sub);
        check_time("R9 last step on disabling edge", 301 * 7);
        repeat (5) @(negedge clk);
        check_time("R9 hold", cur);
        wr(4'd4, 32'd3);
        wr(4'd5, 32'd998);
        wr(4'd0, 32'h8);
        repeat (3) @(negedge clk);
        rd(4'd0, d); check("R9 update pending", d, 32'h8);
        check_time("R9 hold with pending update", cur);

        // R3 update with carry, then R4 resumes
        wr(4'd0, 32'h9);
        check_time("R3 not yet", cur);
        @(negedge clk);
        tot = cur + 3 * ROLL + 998;
        check_time("R3 R5 update add", tot);
        rd(4'd0, d); check("R3 self clear", d, 32'h1);
        @(negedge clk);
        check_time("R4 after update", tot + 7);

        // R6 fine mode, addend quarter range
        do_reset();
        wr(4'd8, 32'd1);
        wr(4'd9, 32'h4000_0000);
        wr(4'd0, 32'h5);
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            check_time("R6 fine quarter", (longint'(k) * 64'h4000_0000) >>> 32);
        end

        // R6 R5 fine mode, three-quarter addend with rollover
        do_reset();
        wr(4'd8, 32'd100);
        wr(4'd9, 32'hC000_0000);
        wr(4'd0, 32'h5);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            check_time("R6 R5 fine", ((longint'(k) * 64'hC000_0000) >>> 32) * 100);
        end

        // R8 alarm disabled
        do_reset();
        wr(4'd8, 32'd10);
        wr(4'd7, 32'd50);
        wr(4'd0, 32'h3);
        repeat (8) @(negedge clk);
        check("R8 flag", alarm_flag, 0);
        rd(4'd1, d); check("R8 status", d, 0);
        check("R8 irq", irq, 0);

        // R7 R10 alarm and interrupt
        do_reset();
        wr(4'd8, 32'd10);
        wr(4'd7, 32'd50);
        wr(4'd0, 32'h23);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check("R7 flag", alarm_flag, (k >= 5) ? 1 : 0);
            check("R10 irq", irq, (k >= 5) ? 1 : 0);
        end
        wr(4'd1, 32'h0);
        check("R10 sticky after write 0", alarm_flag, 1);
        wr(4'd1, 32'h1);
        check("R10 cleared", alarm_flag, 0);
        check("R10 irq cleared", irq, 0);
        rd(4'd1, d); check("R10 status", d, 0);

        // R7 seconds word match, R10 irq masked
        do_reset();
        wr(4'd8, 32'd250);
        wr(4'd6, 32'd1);
        wr(4'd7, 32'd250);
        wr(4'd0, 32'h21);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check("R7 sec match", alarm_flag, (k >= 5) ? 1 : 0);
            check("R10 irq masked", irq, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule